// File: doc/BRIEF.md
# Way-Gated Four-Way Instruction Cache

This block is a small read-only cache placed between a low-power core's AHB-Lite read port and the refill port of a flash controller. It holds 2 kB of instructions in four ways. Each way has 8 sets, and each line is 16 words of 32 bits. On every access the tag and valid bits of all four ways in the indexed set are compared during the address phase. Only the data array of the way that hit is then clocked, so the other three arrays draw no read power.

On a miss the block stalls the bus and requests the line-aligned address of the missed line. It writes the 16 returned words into a victim way, marks the line valid, and then returns the requested word. An empty way in the set is always used first. When the set is full, the way is picked by a free-running LFSR, and no usage history is kept. A single-cycle input drops every valid bit at once.

Top module: `icache_wg`

## Requirements
- R1: After reset, `hreadyout` is 1, `rf_req` is 0, `way_en` is all zero, and every line is invalid, so the first access to any address misses.
- R2: A 32-bit address is split as follows. Bits [1:0] are the byte offset and are ignored. Bits [5:2] select the word in the line. Bits [8:6] select the set. Bits [31:9] form the tag.
- R3: A valid read that hits returns the addressed word on `hrdata`, with `hreadyout` high, in the cycle right after its address phase.
- R4: During the address phase of a hit, `way_en` is the one-hot bit of the hitting way (bit n for way n). During the address phase of a miss, `way_en` is zero.
- R5: Starting in the data phase of a miss, `hreadyout` is low. `rf_req` stays high, with `rf_addr` equal to the missed address with bits [5:0] cleared, until 16 beats have been accepted.
- R6: A beat is accepted on every clock edge where `rf_valid` is high during a refill. Beats carry the words of the line in order, word 0 first. During an accepted beat, `way_en` is the one-hot bit of the victim way. It is zero in refill cycles without a beat.
- R7: In the cycle after the 16th beat, `hreadyout` is high, `rf_req` is low and `hrdata` holds the requested word. A later read of any word of that line hits.
- R8: The victim is the lowest-numbered invalid way of the set, if there is one. Otherwise it is the way given by the two low bits of the LFSR.
- R9: The victim LFSR is 8 bits wide, advances on every clock and never holds zero, so victims in full sets vary over time.
- R10: A cycle with `inv_all` high clears every valid bit. Later reads miss until their lines are refilled.
- R11: A cycle with `hsel` low, with `htrans[1]` low, or with `hready` low (outside a refill) starts no access. No way is enabled, no refill is requested and `hreadyout` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| inv_all | input | 1 | Clear all valid bits this cycle |
| hsel | input | 1 | AHB-Lite slave select |
| htrans | input | 2 | AHB-Lite transfer type; bit 1 marks NONSEQ/SEQ |
| haddr | input | 32 | AHB-Lite byte address |
| hready | input | 1 | AHB-Lite bus ready from the interconnect |
| hreadyout | output | 1 | Slave ready; low while a refill is in progress |
| hrdata | output | 32 | Read data in the data phase |
| rf_req | output | 1 | Line refill request, held for the whole refill |
| rf_addr | output | 32 | Line-aligned refill address |
| rf_valid | input | 1 | Refill beat valid |
| rf_data | input | 32 | Refill beat word |
| way_en | output | 4 | Per-way data array enable (read or write) |

## Verification
The bench fills one set with five different tags. A design that ignored empty ways, or chose them in a different order, would name the wrong victim on the first four fills. Refill beats arrive with random gaps. A design that advanced its word counter without a beat would store shifted data and return the wrong critical word. After an invalidate pulse, an earlier hit has to miss again and land in way 0; stale valid bits would show up as a hit. Idle and unselected transfers are mixed in to catch a design that enables a data array, or starts a refill, without a valid transfer.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } fill_st_e;

endpackage

// File: rtl/icache_lfsr.sv
module icache_lfsr #(
  parameter int          W    = 8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter logic [W-1:0] TAPS = 8'hB8
) (
  input  logic         clk,
  input  logic         rst_n,
  output logic [W-1:0] state
);

  logic [W-1:0] st_q, st_d;

  always_comb begin
    st_d = {st_q[W-2:0], ^(st_q & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= SEED;
    else        st_q <= st_d;
  end

  assign state = st_q;

  a_r9_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != '0);
  a_r9_lfsr_moves: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (st_q != $past(st_q)));

endmodule

// File: rtl/icache_tags.sv
module icache_tags #(
  parameter int NWAYS = 4,
  parameter int NSETS = 8,
  parameter int TAG_W = 23,
  localparam int SET_W = $clog2(NSETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inv_all,
  input  logic [SET_W-1:0] lk_set,
  input  logic [TAG_W-1:0] lk_tag,
  output logic [NWAYS-1:0] hit_vec,
  output logic [NWAYS-1:0] vld_vec,
  input  logic             wr_en,
  input  logic [SET_W-1:0] wr_set,
  input  logic [NWAYS-1:0] wr_way,
  input  logic [TAG_W-1:0] wr_tag
);

  logic [NSETS-1:0][NWAYS-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]            tag_q [NWAYS][NSETS];

  always_comb begin
    vld_d = vld_q;
    if (wr_en)   vld_d[wr_set] = vld_q[wr_set] | wr_way;
    if (inv_all) vld_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int w = 0; w < NWAYS; w++) begin
        if (wr_way[w]) tag_q[w][wr_set] <= wr_tag;
      end
    end
  end

  always_comb begin
    vld_vec = vld_q[lk_set];
    for (int w = 0; w < NWAYS; w++) begin
      hit_vec[w] = vld_q[lk_set][w] && (tag_q[w][lk_set] == lk_tag);
    end
  end

  a_r10_inv_clears: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (vld_q == '0));
  a_r7_fill_marks_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !inv_all) |=> ((vld_q[$past(wr_set)] & $past(wr_way)) == $past(wr_way)));

endmodule

// File: rtl/icache_way_ram.sv
module icache_way_ram #(
  parameter int DEPTH = 128,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ce) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end

endmodule

// File: rtl/icache_wg.sv
module icache_wg
  import icache_pkg::*;
#(
  parameter int NWAYS      = 4,
  parameter int NSETS      = 8,
  parameter int LINE_WORDS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inv_all,
  input  logic        hsel,
  input  logic [1:0]  htrans,
  input  logic [31:0] haddr,
  input  logic        hready,
  output logic        hreadyout,
  output logic [31:0] hrdata,
  output logic        rf_req,
  output logic [31:0] rf_addr,
  input  logic        rf_valid,
  input  logic [31:0] rf_data,
  output logic [3:0]  way_en
);

  localparam int WAY_W  = $clog2(NWAYS);
  localparam int WOFF_W = $clog2(LINE_WORDS);
  localparam int SET_W  = $clog2(NSETS);
  localparam int LO_W   = WOFF_W + 2;
  localparam int TAG_W  = 32 - LO_W - SET_W;
  localparam int RAM_AW = SET_W + WOFF_W;
  localparam logic [WOFF_W-1:0] LAST_BEAT = WOFF_W'(LINE_WORDS - 1);
  localparam logic [NWAYS-1:0]  ONE_WAY   = {{(NWAYS-1){1'b0}}, 1'b1};

  // address-phase fields
  logic [WOFF_W-1:0] a_woff;
  logic [SET_W-1:0]  a_set;
  logic [TAG_W-1:0]  a_tag;
  assign a_woff = haddr[LO_W-1:2];
  assign a_set  = haddr[LO_W+SET_W-1:LO_W];
  assign a_tag  = haddr[31:LO_W+SET_W];

  fill_st_e          st_q, st_d;
  logic [TAG_W-1:0]  mtag_q, mtag_d;
  logic [SET_W-1:0]  mset_q, mset_d;
  logic [WOFF_W-1:0] mwoff_q, mwoff_d;
  logic [WOFF_W-1:0] beat_q, beat_d;
  logic [NWAYS-1:0]  vic_q, vic_d;
  logic [NWAYS-1:0]  hway_q, hway_d;
  logic [31:0]       crit_q, crit_d;

  logic [NWAYS-1:0]  hit_vec, vld_vec, vic_pick;
  logic [NWAYS-1:0]  rd_en, wr_en_w, way_ce;
  logic              take, hit, fill_beat, fill_last, found;
  logic [7:0]        lfsr;
  logic [RAM_AW-1:0] ram_a;
  logic [31:0]       ram_q [NWAYS];
  logic [31:0]       rd_mux;
  logic              unused_ok;

  assign unused_ok = ^{haddr[1:0], htrans[0], lfsr[7:WAY_W]};

  assign take      = hsel && htrans[1] && hready && (st_q != ST_FILL);
  assign hit       = |hit_vec;
  assign fill_beat = (st_q == ST_FILL) && rf_valid;
  assign fill_last = fill_beat && (beat_q == LAST_BEAT);

  icache_lfsr #(.W(8), .SEED(8'h01), .TAPS(8'hB8)) u_lfsr (
    .clk   (clk),
    .rst_n (rst_n),
    .state (lfsr)
  );

  icache_tags #(.NWAYS(NWAYS), .NSETS(NSETS), .TAG_W(TAG_W)) u_tags (
    .clk     (clk),
    .rst_n   (rst_n),
    .inv_all (inv_all),
    .lk_set  (a_set),
    .lk_tag  (a_tag),
    .hit_vec (hit_vec),
    .vld_vec (vld_vec),
    .wr_en   (fill_last),
    .wr_set  (mset_q),
    .wr_way  (vic_q),
    .wr_tag  (mtag_q)
  );

  // victim: lowest empty way, else LFSR choice
  always_comb begin
    vic_pick = '0;
    found    = 1'b0;
    for (int w = 0; w < NWAYS; w++) begin
      if (!found && !vld_vec[w]) begin
        vic_pick[w] = 1'b1;
        found       = 1'b1;
      end
    end
    if (!found) vic_pick = ONE_WAY << lfsr[WAY_W-1:0];
  end

  // next state
  always_comb begin
    st_d    = st_q;
    mtag_d  = mtag_q;
    mset_d  = mset_q;
    mwoff_d = mwoff_q;
    beat_d  = beat_q;
    vic_d   = vic_q;
    hway_d  = hway_q;
    crit_d  = crit_q;
    if (take) begin
      if (hit) begin
        hway_d = hit_vec;
        st_d   = ST_IDLE;
      end else begin
        mtag_d  = a_tag;
        mset_d  = a_set;
        mwoff_d = a_woff;
        vic_d   = vic_pick;
        beat_d  = '0;
        st_d    = ST_FILL;
      end
    end else if (fill_beat) begin
      beat_d = beat_q + 1'b1;
      if (beat_q == mwoff_q) crit_d = rf_data;
      if (fill_last)         st_d   = ST_DONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      mtag_q  <= '0;
      mset_q  <= '0;
      mwoff_q <= '0;
      beat_q  <= '0;
      vic_q   <= '0;
      hway_q  <= '0;
      crit_q  <= '0;
    end else begin
      st_q    <= st_d;
      mtag_q  <= mtag_d;
      mset_q  <= mset_d;
      mwoff_q <= mwoff_d;
      beat_q  <= beat_d;
      vic_q   <= vic_d;
      hway_q  <= hway_d;
      crit_q  <= crit_d;
    end
  end

  // way-gated data arrays
  assign ram_a = (st_q == ST_FILL) ? {mset_q, beat_q} : {a_set, a_woff};

  for (genvar w = 0; w < NWAYS; w++) begin : g_way
    assign rd_en[w]   = take && hit_vec[w];
    assign wr_en_w[w] = fill_beat && vic_q[w];
    assign way_ce[w]  = rd_en[w] | wr_en_w[w];
    icache_way_ram #(.DEPTH(NSETS * LINE_WORDS), .DW(32)) u_ram (
      .clk   (clk),
      .ce    (way_ce[w]),
      .we    (wr_en_w[w]),
      .addr  (ram_a),
      .wdata (rf_data),
      .rdata (ram_q[w])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int w = 0; w < NWAYS; w++) begin
      if (hway_q[w]) rd_mux = rd_mux | ram_q[w];
    end
  end

  assign hrdata    = (st_q == ST_DONE) ? crit_q : rd_mux;
  assign hreadyout = (st_q != ST_FILL);
  assign rf_req    = (st_q == ST_FILL);
  assign rf_addr   = {mtag_q, mset_q, {LO_W{1'b0}}};
  assign way_en    = way_ce;

  a_r4_one_way_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(way_en));
  a_r3_hit_ready_next: assert property (@(posedge clk) disable iff (!rst_n)
    (take && hit) |=> hreadyout);
  a_r5_miss_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !hit) |=> (!hreadyout && rf_req));
  a_r5_line_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    rf_req |-> (rf_addr[LO_W-1:0] == '0));
  a_r5_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_req && $past(rf_req)) |-> $stable(rf_addr));
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!(hsel && htrans[1] && hready) && !rf_req) |-> (way_en == '0));
  a_r7_done_ready: assert property (@(posedge clk) disable iff (!rst_n)
    fill_last |=> (hreadyout && !rf_req));

endmodule

// File: tb/sim_icache_wg.sv
module sim_icache_wg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        inv_all;
  logic        hsel;
  logic [1:0]  htrans;
  logic [31:0] haddr;
  logic        hready;
  logic        hreadyout;
  logic [31:0] hrdata;
  logic        rf_req;
  logic [31:0] rf_addr;
  logic        rf_valid;
  logic [31:0] rf_data;
  logic [3:0]  way_en;

  int n_chk = 0;
  int n_fail = 0;
  int vic_hist [4];
  int full_evicts = 0;

  bit         mv [8][4];
  logic [22:0] mt [8][4];

  always #4 clk = ~clk;

  assign hready = hreadyout;

  icache_wg u0 (
    .clk(clk), .rst_n(rst_n), .inv_all(inv_all), .hsel(hsel), .htrans(htrans),
    .haddr(haddr), .hready(hready), .hreadyout(hreadyout), .hrdata(hrdata),
    .rf_req(rf_req), .rf_addr(rf_addr), .rf_valid(rf_valid), .rf_data(rf_data),
    .way_en(way_en)
  );

  function automatic logic [31:0] fdata(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h9E37_79B1) ^ 32'h1234_ABCD;
  endfunction

  function automatic int mhit(input logic [31:0] a);
    int r;
    r = -1;
    for (int w = 0; w < 4; w++)
      if (mv[a[8:6]][w] && mt[a[8:6]][w] == a[31:9]) r = w;
    return r;
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic rd(input logic [31:0] a);
    int   w;
    int   exp_v;
    int   beat;
    int   vic;
    logic [31:0] line;
    w = mhit(a);
    line = {a[31:6], 6'b0};
    @(negedge clk);
    hsel = 1'b1; htrans = 2'b10; haddr = a;
    #1;
    chk(way_en == ((w >= 0) ? (4'b1 << w) : 4'b0), "R4 address-phase way_en", {28'b0, way_en},
        (w >= 0) ? (32'b1 << w) : 32'b0);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b00;
    if (w >= 0) begin
      chk(hreadyout == 1'b1, "R3 hit ready", {31'b0, hreadyout}, 32'd1);
      chk(hrdata == fdata(a), "R3 hit data", hrdata, fdata(a));
    end else begin
      chk(!hreadyout && rf_req, "R5 miss stall", {30'b0, hreadyout, rf_req}, 32'd1);
      chk(rf_addr == line, "R5/R2 refill addr", rf_addr, line);
      exp_v = -1;
      for (int k = 3; k >= 0; k--) if (!mv[a[8:6]][k]) exp_v = k;
      beat = 0;
      vic  = -1;
      while (beat < 16) begin
        rf_valid = (($urandom % 4) != 0);
        rf_data  = fdata(line + 32'(beat * 4));
        #1;
        chk(!hreadyout, "R5 stall during refill", {31'b0, hreadyout}, 32'd0);
        if (rf_valid) begin
          if (beat == 0) begin
            for (int k = 0; k < 4; k++) if (way_en == (4'b1 << k)) vic = k;
            if (exp_v >= 0)
              chk(vic == exp_v, "R8 empty way first", 32'(vic), 32'(exp_v));
            else begin
              chk(vic >= 0, "R8 victim one-hot", {28'b0, way_en}, 32'd0);
              full_evicts++;
              if (vic >= 0) vic_hist[vic]++;
            end
          end else begin
            chk(vic >= 0 && way_en == (4'b1 << vic), "R6 beat to victim", {28'b0, way_en},
                32'b1 << vic);
          end
          beat++;
        end else begin
          chk(way_en == 4'b0, "R6 no beat no enable", {28'b0, way_en}, 32'd0);
        end
        @(negedge clk);
      end
      rf_valid = 1'b0;
      chk(hreadyout && !rf_req, "R7 ready after refill", {30'b0, hreadyout, rf_req}, 32'd2);
      chk(hrdata == fdata(a), "R7 critical word", hrdata, fdata(a));
      if (vic >= 0) begin
        mv[a[8:6]][vic] = 1'b1;
        mt[a[8:6]][vic] = a[31:9];
      end
    end
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] a;
    int d;
    for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) begin mv[s][w] = 0; mt[s][w] = '0; end
    for (int w = 0; w < 4; w++) vic_hist[w] = 0;
    void'($urandom(32'd7741));
    rst_n = 1'b0; inv_all = 1'b0; hsel = 1'b0; htrans = 2'b00; haddr = '0;
    rf_valid = 1'b0; rf_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(hreadyout && !rf_req && way_en == 4'b0, "R1 reset outputs",
        {27'b0, way_en, rf_req, hreadyout} , 32'd1);

    // R11 idle and unselected transfers
    hsel = 1'b1; htrans = 2'b00; haddr = 32'h0000_0040;
    #1 chk(way_en == 4'b0, "R11 idle htrans way_en", {28'b0, way_en}, 32'd0);
    @(negedge clk);
    hsel = 1'b0; htrans = 2'b10;
    #1 chk(way_en == 4'b0, "R11 unselected way_en", {28'b0, way_en}, 32'd0);
    @(negedge clk);
    htrans = 2'b00;
    chk(hreadyout && !rf_req, "R11 no refill started", {30'b0, hreadyout, rf_req}, 32'd2);

    // R1 first access misses, R2 byte offset ignored
    rd(32'h0000_1234);
    rd(32'h0000_1236);
    rd(32'h0000_1238);

    // R8 fill one set with five tags
    for (int t = 1; t <= 5; t++) rd({23'(t * 3), 3'd3, 4'(t), 2'b00});
    for (int t = 1; t <= 5; t++) rd({23'(t * 3), 3'd3, 4'(15 - t), 2'b00});

    // R10 invalidate all
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int s = 0; s < 8; s++) for (int w = 0; w < 4; w++) mv[s][w] = 0;
    rd(32'h0000_1234);  // R10 must miss and go to way 0

    // random traffic, R3 R6 R7 R8 R9
    for (int i = 0; i < 400; i++) begin
      a = {23'($urandom % 7) + 23'h40, 3'($urandom % 8), 4'($urandom % 16), 2'($urandom % 4)};
      rd(a);
      d = $urandom % 3;
      repeat (d) @(negedge clk);
    end

    // R9 victims in full sets are not all the same way
    d = 0;
    for (int w = 0; w < 4; w++) if (vic_hist[w] > 0) d++;
    chk(full_evicts >= 8 && d >= 2, "R9 varied victims", 32'(d), 32'd2);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule